// File: doc/BRIEF.md
# Pipelined Multiply-Add Unit

This unit computes a multiply-add or a multiply-subtract. It takes two 64-bit multiplicands, A and B, and a 128-bit addend, C. It returns either C + A*B or C - A*B as a 128-bit result, reduced modulo 2^128. Each operation carries two flags. The first selects whether both multiplicands are two's-complement signed or unsigned. The second selects subtraction. With that second flag the caller gets C - A*B directly, with no need to complement the addend or the result.

The unit has a fixed latency, set by a parameter, and it accepts one operation per clock. Results leave in issue order, each marked by a valid pulse. It has no word-size mode; narrower multiplies belong to a separate unit.

Internally the unsigned product is built from limb-sized partial products. In signed mode a sign-correction term is subtracted from that product. The resulting product is negated in full width when subtraction is requested, and then added to the addend.

Top module: `mac_unit`

## Requirements
- R1: With `in_signed` = 0, both multiplicands are unsigned, so `out_result` equals (C + A*B) mod 2^128 or (C - A*B) mod 2^128, with A and B zero-extended.
- R2: With `in_signed` = 1, both multiplicands are two's complement. For example, A = 0x8000_0000_0000_0000 is -2^63 and all-ones is -1.
- R3: With `in_sub` = 0, the result is the addend plus the product, modulo 2^128.
- R4: With `in_sub` = 1, the result is the addend minus the product, modulo 2^128.
- R5: An operation accepted at a rising edge with `in_valid` = 1 appears on `out_result` with `out_valid` = 1 exactly LATENCY rising edges later (default 2).
- R6: While `rst_n` is low at a rising edge, `out_valid` is 0 after that edge.
- R7: A cycle with `in_valid` = 0 produces no output pulse. `out_valid` rises only for accepted operations.
- R8: Operations may be issued on consecutive cycles with different flag settings. Each result uses its own flags and leaves in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept an operation this cycle |
| in_a | input | OP_W | Multiplicand A |
| in_b | input | OP_W | Multiplicand B |
| in_c | input | 2*OP_W | Addend C |
| in_signed | input | 1 | 1: signed multiplicands, 0: unsigned |
| in_sub | input | 1 | 1: C - A*B, 0: C + A*B |
| out_valid | output | 1 | Result valid pulse |
| out_result | output | 2*OP_W | Result modulo 2^(2*OP_W) |

## Verification
The assertions assume that `rst_n` is held low for at least LATENCY cycles at start-up. They also assume that `in_valid` is never unknown after reset. The stimulus keeps within both: every input is driven on the falling edge from a defined value, and reset is held for several cycles.

The flag and operand inputs may take any value whenever `in_valid` is high. The operand set covers zero, one, all-ones, the most negative value and the most positive value, in both modes and both subtract settings. Some issues are back-to-back and some are separated by idle gaps.

// File: rtl/mac_pkg.sv
// mac_pkg: default sizes shared by the multiply-add unit and its sub-blocks.
// Assumes the operand width is a multiple of the limb width.
package mac_pkg;
    localparam int DEF_OP_W    = 64;
    localparam int DEF_LIMB_W  = 32;
    localparam int DEF_LATENCY = 2;

    // Number of limbs an operand splits into.
    function automatic int limb_count(input int op_w, input int limb_w);
        return op_w / limb_w;
    endfunction
endpackage

// File: rtl/mac_limb_mult.sv
// mac_limb_mult: unsigned OP_W x OP_W multiplier built from limb products.
// Assumes OP_W is a multiple of LIMB_W. Purely combinational.
module mac_limb_mult #(
    parameter int OP_W   = mac_pkg::DEF_OP_W,
    parameter int LIMB_W = mac_pkg::DEF_LIMB_W
) (
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    output logic [2*OP_W-1:0] prod
);
    localparam int NL    = mac_pkg::limb_count(OP_W, LIMB_W);
    localparam int RES_W = 2 * OP_W;
    localparam int PP_W  = 2 * LIMB_W;

    logic [PP_W-1:0] pp [NL*NL];

    // One partial product for each pair of limbs.
    for (genvar i = 0; i < NL; i++) begin : g_ai
        for (genvar j = 0; j < NL; j++) begin : g_bj
            logic [PP_W-1:0] a_ext, b_ext;
            assign a_ext = PP_W'(a[i*LIMB_W +: LIMB_W]);
            assign b_ext = PP_W'(b[j*LIMB_W +: LIMB_W]);
            assign pp[i*NL+j] = a_ext * b_ext;
        end
    end

    // Shift each partial product to its weight and add them all.
    always_comb begin
        prod = '0;
        for (int i = 0; i < NL; i++) begin
            for (int j = 0; j < NL; j++) begin
                prod = prod + (RES_W'(pp[i*NL+j]) << ((i + j) * LIMB_W));
            end
        end
    end
endmodule

// File: rtl/mac_sign_fix.sv
// mac_sign_fix: correction that turns an unsigned product into a signed one.
// signed(A)*signed(B) = A*B - 2^OP_W*(a_msb*B + b_msb*A) mod 2^(2*OP_W).
// Assumes the caller subtracts the returned term. The term is zero in unsigned mode.
module mac_sign_fix #(
    parameter int OP_W = mac_pkg::DEF_OP_W
) (
    input  logic              is_signed,
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    output logic [2*OP_W-1:0] corr
);
    localparam int RES_W = 2 * OP_W;

    logic [OP_W-1:0] a_part, b_part;

    // Select B when A is negative, and A when B is negative.
    always_comb begin
        a_part = a[OP_W-1] ? b : '0;
        b_part = b[OP_W-1] ? a : '0;
    end

    // Weight the correction by 2^OP_W, only in signed mode.
    always_comb begin
        if (is_signed)
            corr = (RES_W'(a_part) + RES_W'(b_part)) << OP_W;
        else
            corr = '0;
    end
endmodule

// File: rtl/mac_accum.sv
// mac_accum: folds the sign correction into the product, negates it for
// subtract, and adds the addend. The arithmetic wraps modulo 2^RES_W.
module mac_accum #(
    parameter int RES_W = 2 * mac_pkg::DEF_OP_W
) (
    input  logic [RES_W-1:0] uprod,
    input  logic [RES_W-1:0] corr,
    input  logic [RES_W-1:0] addend,
    input  logic             sub,
    output logic [RES_W-1:0] sum
);
    logic [RES_W-1:0] sprod, term;

    // Signed product (equal to the unsigned product when corr is zero).
    always_comb sprod = uprod - corr;

    // Two's complement of the full-width product for subtract.
    always_comb term = sub ? (~sprod + RES_W'(1)) : sprod;

    // Final accumulation.
    always_comb sum = addend + term;
endmodule

// File: rtl/mac_unit.sv
// mac_unit: pipelined multiply-add, giving C + A*B or C - A*B modulo 2^(2*OP_W).
// Stage 1 registers the operands. Stage 2 registers the sum. LATENCY-2
// further delay stages follow. Assumes LATENCY >= 2 and synchronous
// active-low reset held for at least LATENCY cycles.
module mac_unit #(
    parameter int OP_W    = mac_pkg::DEF_OP_W,
    parameter int LIMB_W  = mac_pkg::DEF_LIMB_W,
    parameter int LATENCY = mac_pkg::DEF_LATENCY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_a,
    input  logic [OP_W-1:0]   in_b,
    input  logic [2*OP_W-1:0] in_c,
    input  logic              in_signed,
    input  logic              in_sub,
    output logic              out_valid,
    output logic [2*OP_W-1:0] out_result
);
    localparam int RES_W = 2 * OP_W;
    localparam int CNT_W = $clog2(LATENCY + 2) + 1;

    initial assert (LATENCY >= 2 && OP_W % LIMB_W == 0)
        else $error("mac_unit: LATENCY must be >= 2 and OP_W a multiple of LIMB_W");

    // Stage 1 operand registers.
    logic              s1_valid;
    logic [OP_W-1:0]   s1_a, s1_b;
    logic [RES_W-1:0]  s1_c;
    logic              s1_signed, s1_sub;

    // Capture the operands; only the valid bit is reset.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= in_valid;
        if (in_valid) begin
            s1_a      <= in_a;
            s1_b      <= in_b;
            s1_c      <= in_c;
            s1_signed <= in_signed;
            s1_sub    <= in_sub;
        end
    end

    logic [RES_W-1:0] uprod, corr, sum;

    mac_limb_mult #(.OP_W(OP_W), .LIMB_W(LIMB_W)) u_mult (
        .a(s1_a), .b(s1_b), .prod(uprod)
    );

    mac_sign_fix #(.OP_W(OP_W)) u_fix (
        .is_signed(s1_signed), .a(s1_a), .b(s1_b), .corr(corr)
    );

    mac_accum #(.RES_W(RES_W)) u_acc (
        .uprod(uprod), .corr(corr), .addend(s1_c), .sub(s1_sub), .sum(sum)
    );

    // Result pipe: index 1 is the sum register, LATENCY-1 drives the port.
    logic             pv [1:LATENCY-1];
    logic [RES_W-1:0] pr [1:LATENCY-1];

    // Register the sum.
    always_ff @(posedge clk) begin
        if (!rst_n) pv[1] <= 1'b0;
        else        pv[1] <= s1_valid;
        if (s1_valid) pr[1] <= sum;
    end

    // Extra delay stages to reach the configured latency.
    for (genvar k = 2; k < LATENCY; k++) begin : g_dly
        // Move one stage down the pipe.
        always_ff @(posedge clk) begin
            if (!rst_n) pv[k] <= 1'b0;
            else        pv[k] <= pv[k-1];
            pr[k] <= pr[k-1];
        end
    end

    assign out_valid  = pv[LATENCY-1];
    assign out_result = pr[LATENCY-1];

    // ---------------- assertions ----------------
    logic [CNT_W-1:0] inflight;

    // Count operations accepted but not yet delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) inflight <= '0;
        else        inflight <= inflight + CNT_W'(in_valid) - CNT_W'(out_valid);
    end

    p_no_spurious_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> inflight != '0);

    p_inflight_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CNT_W'(LATENCY));

    p_reset_clears_r6: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    p_unsigned_no_fix_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_signed) |-> corr == '0);

    p_zero_factor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && (s1_a == '0 || s1_b == '0)) |-> sum == s1_c);

    p_result_known_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_result));
endmodule

// File: tb/test_mac_unit.sv
// Scoreboard bench: the driver queues expected results, the monitor compares them.
module test_mac_unit;
    localparam int OP_W = 64;
    localparam int RES_W = 128;
    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [OP_W-1:0] in_a = '0, in_b = '0;
    logic [RES_W-1:0] in_c = '0;
    logic in_signed = 1'b0, in_sub = 1'b0;
    logic out_valid;
    logic [RES_W-1:0] out_result;

    always #5 clk = ~clk;

    mac_unit #(.OP_W(OP_W), .LIMB_W(32), .LATENCY(LAT)) i_mac_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_c(in_c), .in_signed(in_signed), .in_sub(in_sub),
        .out_valid(out_valid), .out_result(out_result)
    );

    typedef struct {
        logic [RES_W-1:0] exp;
        int               due;
        logic             sgn;
        logic             sub;
    } item_t;

    item_t sb[$];
    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Expected value from R1..R4: extend, multiply, add or subtract, wrap.
    function automatic logic [RES_W-1:0] model(input logic [OP_W-1:0] a, b,
            input logic [RES_W-1:0] c, input logic sgn, sub);
        logic [RES_W-1:0] ea, eb, p;
        ea = sgn ? {{OP_W{a[OP_W-1]}}, a} : {{OP_W{1'b0}}, a};
        eb = sgn ? {{OP_W{b[OP_W-1]}}, b} : {{OP_W{1'b0}}, b};
        p = ea * eb;
        return sub ? c - p : c + p;
    endfunction

    task automatic issue(input logic [OP_W-1:0] a, b, input logic [RES_W-1:0] c,
            input logic sgn, sub);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1; in_a = a; in_b = b; in_c = c; in_signed = sgn; in_sub = sub;
        it.exp = model(a, b, c, sgn, sub);
        it.due = cyc + LAT;
        it.sgn = sgn;
        it.sub = sub;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare at each falling edge (R5 timing, R7 no spurious, R8 order).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                checks++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL R7: out_valid=1 act=%h exp=no output", out_result);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    if (it.due != cyc) begin
                        fails++;
                        $display("FAIL R5: result at cycle act=%0d exp=%0d", cyc, it.due);
                    end
                    if (out_result !== it.exp) begin
                        fails++;
                        $display("FAIL %s/%s R8: act=%h exp=%h",
                                 it.sgn ? "R2" : "R1", it.sub ? "R4" : "R3",
                                 out_result, it.exp);
                    end
                end
            end else if (sb.size() != 0 && sb[0].due <= cyc) begin
                checks++;
                fails++;
                $display("FAIL R5: out_valid act=0 exp=1 at cycle %0d", cyc);
                void'(sb.pop_front());
            end
        end
    end

    // Watchdog.
    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog: act=timeout exp=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    logic [OP_W-1:0] vals [5];

    initial begin
        vals[0] = '0;
        vals[1] = '1;
        vals[2] = {1'b1, {(OP_W-1){1'b0}}};
        vals[3] = {1'b0, {(OP_W-1){1'b1}}};
        vals[4] = 64'd1;

        repeat (4) @(negedge clk);
        // R6: output quiet during and right after reset.
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R6: out_valid act=%b exp=0", out_valid);
        end
        rst_n = 1'b1;
        idle(3);
        // R7: idle cycles give no output.
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R7: idle out_valid act=%b exp=0", out_valid);
        end

        // Corner operands, both modes and both subtract settings, back to back (R8).
        for (int m = 0; m < 4; m++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    issue(vals[i], vals[j], {vals[j], vals[i]} ^ RES_W'(i*7 + j),
                          m[0], m[1]);
        idle(4);

        // Alternating flags with gaps (R5, R7, R8).
        for (int k = 0; k < 40; k++) begin
            issue({$urandom, $urandom}, {$urandom, $urandom},
                  {$urandom, $urandom, $urandom, $urandom}, k[0], k[1]);
            if (k % 3 == 0) idle(k % 4 + 1);
        end
        // Most negative squared, signed subtract from zero (R2, R4).
        issue(vals[2], vals[2], '0, 1'b1, 1'b1);
        // All-ones times all-ones unsigned add with all-ones addend (R1, R3).
        issue(vals[1], vals[1], '1, 1'b0, 1'b0);
        idle(LAT + 4);

        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R5: pending results act=%0d exp=0", sb.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule